// File: doc/BRIEF.md
# Direct GET Command Responder for a Bus Target

This block answers the direct "get" common commands that a bus controller sends to an I3C target. The bus front end handles bit timing. It reports the command code and an optional defining byte, then the repeated START, then each address phase that follows. When the address matches this target with the read direction, the block accepts the address. It then serves the response one byte at a time and flags the final byte, so that the front end can drive the T bit low and end the read.

The response bytes are never captured into a snapshot. Each byte is selected from the live source value at the moment the front end asks for it. If a source changes during a transfer, the bytes already sent keep the old value and the remaining bytes carry the new one. The sources are:
- the device and bus characteristic bytes;
- a provisioned ID assembled from a high word and a low word;
- a status word carrying the protocol-error flag;
- the maximum-write-length, maximum-read-length and in-band-interrupt-length flops;
- the capability bytes;
- a fixed recovery-time byte.

The controlling state machine has four states:
- IDLE: no command is pending.
- ARMED: a command has been captured and the block waits for an address.
- SEND: bytes are being served.
- DONE: the last byte has been served and the block waits for the end of the frame.

The transitions are:
- capture: any state to ARMED on a command strobe.
- accept: ARMED to SEND on a matching read address with a supported command.
- reject: ARMED to IDLE on a matching address that is refused.
- finish: SEND to DONE when the last byte is consumed.
- rearm: SEND or DONE to ARMED on a repeated START.
- abort: any state to IDLE on STOP.

Top module: `getccc_responder`

## Requirements
- R1: The response length is fixed by the command code. It is 1 byte for 0x8E (bus characteristics), 1 byte for 0x8F (device characteristics), 2 bytes for 0x90 (status), 2 bytes for 0x8B (write length) and 3 bytes for 0x8C (read length). Each of these is accepted only when no defining byte was sent.
- R2: Multi-byte values are served most significant byte first. Code 0x8D returns 6 bytes, the 32-bit high ID word followed by the 16-bit low ID word. Code 0x8C returns the read length MSB, then the read length LSB, then the interrupt-length byte.
- R3: Each byte is taken from the source value present when that byte is served. A source change during a transfer alters only the bytes not yet served.
- R4: In the 0x90 response, bit 5 of the 16-bit word (bit 5 of the second byte) equals the protocol-error input. The other 15 bits come from the status input.
- R5: Code 0x95 with no defining byte returns the 2 capability bytes. Code 0x95 with defining byte 0x93 returns the single extended-capability byte.
- R6: Code 0x9A with defining byte 0x81, 0x82 or 0x84 returns the single byte 0xFF. Code 0x9A with any other defining byte, or with none, is refused.
- R7: A matching address with the write direction is refused, as are an unsupported defining byte and an unknown code. A refusal sends the block to IDLE, so a later matching address is also refused until a new command arrives.
- R8: An address that does not match is not acknowledged, and the block stays armed for a later address.
- R9: `tx_last` is high exactly while the final byte is offered. Once that byte is consumed, `tx_valid` drops.
- R10: A repeated START during SEND or DONE rearms the same command with the byte count cleared, so the next accepted address starts again at the first byte. A STOP returns the block to IDLE.
- R11: After reset the block is in IDLE: `tx_valid` and `addr_ack` are low, and an address phase is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_strobe | input | 1 | Pulse: a direct command code was received |
| cmd_code | input | 8 | Command code |
| cmd_has_db | input | 1 | A defining byte accompanies the code |
| cmd_db | input | 8 | Defining byte value |
| addr_strobe | input | 1 | Pulse: address phase after a repeated START |
| addr_match | input | 1 | The address equals this target's address |
| addr_rnw | input | 1 | Direction bit, 1 = read |
| addr_ack | output | 1 | Accept the address (combinational, in the strobe cycle) |
| byte_req | input | 1 | Front end consumes the offered byte |
| tx_valid | output | 1 | A response byte is offered |
| tx_byte | output | 8 | Offered response byte |
| tx_last | output | 1 | The offered byte is the final one |
| bus_stop | input | 1 | STOP seen on the bus |
| bus_rstart | input | 1 | Repeated START seen on the bus |
| dcr_in | input | 8 | Device characteristics byte |
| bcr_in | input | 8 | Bus characteristics byte |
| pid_hi_in | input | 32 | High word of the provisioned ID |
| pid_lo_in | input | 16 | Low word of the provisioned ID |
| status_in | input | 16 | Status word |
| proto_err | input | 1 | Protocol-error flag |
| mwl_q | input | 16 | Maximum write length flop |
| mrl_q | input | 16 | Maximum read length flop |
| ibil_q | input | 8 | Interrupt payload length flop |
| caps_in | input | 16 | Capability bytes |
| caps_ext_in | input | 8 | Extended capability byte |

## Verification
The bench builds the block with its defaults: a 32-bit high ID word, a 16-bit low ID word, two capability bytes and the error flag at status bit 5. With these defaults the longest response is six bytes, so the byte counter reaches its full range. The bench also runs the three-byte read-length ordering and a source change between the second and third byte of the ID, and checks that only the bytes served after the change differ.

// File: rtl/getccc_pkg.sv
package getccc_pkg;

    localparam logic [7:0] CODE_GET_WLEN   = 8'h8B;
    localparam logic [7:0] CODE_GET_RLEN   = 8'h8C;
    localparam logic [7:0] CODE_GET_ID     = 8'h8D;
    localparam logic [7:0] CODE_GET_BUSCH  = 8'h8E;
    localparam logic [7:0] CODE_GET_DEVCH  = 8'h8F;
    localparam logic [7:0] CODE_GET_STAT   = 8'h90;
    localparam logic [7:0] CODE_GET_CAPS   = 8'h95;
    localparam logic [7:0] CODE_RESET_ACT  = 8'h9A;

    localparam logic [7:0] DB_CAPS_EXT     = 8'h93;
    localparam logic [7:0] DB_RECOV_A      = 8'h81;
    localparam logic [7:0] DB_RECOV_B      = 8'h82;
    localparam logic [7:0] DB_RECOV_C      = 8'h84;
    localparam logic [7:0] RECOV_TIME_BYTE = 8'hFF;

    typedef enum logic [3:0] {
        SRC_NONE,
        SRC_BUSCH,
        SRC_DEVCH,
        SRC_STAT,
        SRC_WLEN,
        SRC_RLEN,
        SRC_ID,
        SRC_CAPS,
        SRC_CAPS_EXT,
        SRC_RECOV
    } src_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SEND,
        ST_DONE
    } resp_state_e;

endpackage

// File: rtl/getccc_decode.sv
module getccc_decode
    import getccc_pkg::*;
(
    input  logic [7:0] code,
    input  logic       has_db,
    input  logic [7:0] db,
    output src_sel_e   sel
);

    logic recov_db;

    always_comb begin
        recov_db = (db == DB_RECOV_A) || (db == DB_RECOV_B) || (db == DB_RECOV_C);
    end

    always_comb begin
        sel = SRC_NONE;
        case (code)
            CODE_GET_BUSCH: sel = has_db ? SRC_NONE : SRC_BUSCH;
            CODE_GET_DEVCH: sel = has_db ? SRC_NONE : SRC_DEVCH;
            CODE_GET_STAT:  sel = has_db ? SRC_NONE : SRC_STAT;
            CODE_GET_WLEN:  sel = has_db ? SRC_NONE : SRC_WLEN;
            CODE_GET_RLEN:  sel = has_db ? SRC_NONE : SRC_RLEN;
            CODE_GET_ID:    sel = has_db ? SRC_NONE : SRC_ID;
            CODE_GET_CAPS: begin
                if (!has_db)                 sel = SRC_CAPS;
                else if (db == DB_CAPS_EXT)  sel = SRC_CAPS_EXT;
                else                         sel = SRC_NONE;
            end
            CODE_RESET_ACT: sel = (has_db && recov_db) ? SRC_RECOV : SRC_NONE;
            default:        sel = SRC_NONE;
        endcase
    end

endmodule

// File: rtl/getccc_src_mux.sv
module getccc_src_mux
    import getccc_pkg::*;
#(
    parameter int ID_HI_W     = 32,
    parameter int ID_LO_W     = 16,
    parameter int CAPS_BYTES  = 2,
    parameter int ERR_BIT     = 5,
    parameter int MAX_BYTES   = 6,
    parameter int CNT_W       = 3
) (
    input  src_sel_e                  sel,
    input  logic [CNT_W-1:0]          cnt,
    input  logic [7:0]                dcr_in,
    input  logic [7:0]                bcr_in,
    input  logic [ID_HI_W-1:0]        pid_hi_in,
    input  logic [ID_LO_W-1:0]        pid_lo_in,
    input  logic [15:0]               status_in,
    input  logic                      proto_err,
    input  logic [15:0]               mwl_q,
    input  logic [15:0]               mrl_q,
    input  logic [7:0]                ibil_q,
    input  logic [CAPS_BYTES*8-1:0]   caps_in,
    input  logic [7:0]                caps_ext_in,
    output logic [7:0]                tx_byte,
    output logic [CNT_W-1:0]          resp_len,
    output logic                      tx_last
);

    localparam int ID_W    = ID_HI_W + ID_LO_W;
    localparam int ID_B    = ID_W / 8;
    localparam int VEC_W   = MAX_BYTES * 8;

    logic [VEC_W-1:0] vec;
    logic [15:0]      stat_word;

    always_comb begin
        stat_word          = status_in;
        stat_word[ERR_BIT] = proto_err;
    end

    // Right-justified response value, rebuilt every cycle from live sources
    always_comb begin
        vec      = '0;
        resp_len = '0;
        unique case (sel)
            SRC_BUSCH:    begin vec[7:0]  = bcr_in;          resp_len = CNT_W'(1); end
            SRC_DEVCH:    begin vec[7:0]  = dcr_in;          resp_len = CNT_W'(1); end
            SRC_STAT:     begin vec[15:0] = stat_word;       resp_len = CNT_W'(2); end
            SRC_WLEN:     begin vec[15:0] = mwl_q;           resp_len = CNT_W'(2); end
            SRC_RLEN:     begin vec[23:0] = {mrl_q, ibil_q}; resp_len = CNT_W'(3); end
            SRC_ID:       begin vec[ID_W-1:0] = {pid_hi_in, pid_lo_in}; resp_len = CNT_W'(ID_B); end
            SRC_CAPS:     begin vec[CAPS_BYTES*8-1:0] = caps_in; resp_len = CNT_W'(CAPS_BYTES); end
            SRC_CAPS_EXT: begin vec[7:0]  = caps_ext_in;     resp_len = CNT_W'(1); end
            SRC_RECOV:    begin vec[7:0]  = RECOV_TIME_BYTE; resp_len = CNT_W'(1); end
            default:      begin vec = '0;                    resp_len = '0; end
        endcase
    end

    // Most significant byte first: byte number cnt sits at slot len-1-cnt
    always_comb begin
        tx_byte = 8'h00;
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (int'(resp_len) - 1 - int'(cnt) == i) begin
                tx_byte = vec[i*8 +: 8];
            end
        end
        tx_last = (resp_len != '0) && (int'(cnt) == int'(resp_len) - 1);
    end

endmodule

// File: rtl/getccc_byte_ctr.sv
module getccc_byte_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (inc)   cnt <= cnt + CNT_W'(1);
    end

    p_ctr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc) |=> (cnt == $past(cnt) + CNT_W'(1)))
        else $error("counter did not advance by one");

    p_ctr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0))
        else $error("counter not cleared");

endmodule

// File: rtl/getccc_responder.sv
module getccc_responder
    import getccc_pkg::*;
#(
    parameter int ID_HI_W    = 32,
    parameter int ID_LO_W    = 16,
    parameter int CAPS_BYTES = 2,
    parameter int ERR_BIT    = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_strobe,
    input  logic [7:0]              cmd_code,
    input  logic                    cmd_has_db,
    input  logic [7:0]              cmd_db,
    input  logic                    addr_strobe,
    input  logic                    addr_match,
    input  logic                    addr_rnw,
    output logic                    addr_ack,
    input  logic                    byte_req,
    output logic                    tx_valid,
    output logic [7:0]              tx_byte,
    output logic                    tx_last,
    input  logic                    bus_stop,
    input  logic                    bus_rstart,
    input  logic [7:0]              dcr_in,
    input  logic [7:0]              bcr_in,
    input  logic [ID_HI_W-1:0]      pid_hi_in,
    input  logic [ID_LO_W-1:0]      pid_lo_in,
    input  logic [15:0]             status_in,
    input  logic                    proto_err,
    input  logic [15:0]             mwl_q,
    input  logic [15:0]             mrl_q,
    input  logic [7:0]              ibil_q,
    input  logic [CAPS_BYTES*8-1:0] caps_in,
    input  logic [7:0]              caps_ext_in
);

    localparam int ID_BYTES  = (ID_HI_W + ID_LO_W) / 8;
    localparam int MAX_A     = (ID_BYTES > CAPS_BYTES) ? ID_BYTES : CAPS_BYTES;
    localparam int MAX_BYTES = (MAX_A > 3) ? MAX_A : 3;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

    resp_state_e      state, state_nx;
    src_sel_e         sel_q, sel_dec;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] resp_len;
    logic             mux_last;
    logic [7:0]       mux_byte;
    logic             addr_hit;
    logic             accept;
    logic             ctr_clr;
    logic             ctr_inc;

    getccc_decode u_decode (
        .code   (cmd_code),
        .has_db (cmd_has_db),
        .db     (cmd_db),
        .sel    (sel_dec)
    );

    getccc_src_mux #(
        .ID_HI_W    (ID_HI_W),
        .ID_LO_W    (ID_LO_W),
        .CAPS_BYTES (CAPS_BYTES),
        .ERR_BIT    (ERR_BIT),
        .MAX_BYTES  (MAX_BYTES),
        .CNT_W      (CNT_W)
    ) u_mux (
        .sel         (sel_q),
        .cnt         (cnt),
        .dcr_in      (dcr_in),
        .bcr_in      (bcr_in),
        .pid_hi_in   (pid_hi_in),
        .pid_lo_in   (pid_lo_in),
        .status_in   (status_in),
        .proto_err   (proto_err),
        .mwl_q       (mwl_q),
        .mrl_q       (mrl_q),
        .ibil_q      (ibil_q),
        .caps_in     (caps_in),
        .caps_ext_in (caps_ext_in),
        .tx_byte     (mux_byte),
        .resp_len    (resp_len),
        .tx_last     (mux_last)
    );

    getccc_byte_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (ctr_inc),
        .cnt   (cnt)
    );

    always_comb begin
        addr_hit = (state == ST_ARMED) && addr_strobe && addr_match;
        accept   = addr_rnw && (sel_q != SRC_NONE);
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (bus_stop) begin
            state_nx = ST_IDLE;                               // abort
        end else if (cmd_strobe) begin
            state_nx = ST_ARMED;                              // capture
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_ARMED: if (addr_hit) state_nx = accept ? ST_SEND : ST_IDLE;  // accept / reject
                ST_SEND: begin
                    if (bus_rstart)                 state_nx = ST_ARMED;        // rearm
                    else if (byte_req && mux_last)  state_nx = ST_DONE;         // finish
                end
                ST_DONE:  if (bus_rstart) state_nx = ST_ARMED;                  // rearm
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel_q <= SRC_NONE;
        end else begin
            state <= state_nx;
            if (cmd_strobe && !bus_stop) sel_q <= sel_dec;
        end
    end

    // Outputs
    always_comb begin
        addr_ack = addr_hit && accept;
        tx_valid = (state == ST_SEND);
        tx_byte  = tx_valid ? mux_byte : 8'h00;
        tx_last  = tx_valid && mux_last;
        ctr_clr  = (state != ST_SEND) || bus_stop || bus_rstart || cmd_strobe;
        ctr_inc  = tx_valid && byte_req;
    end

    p_ack_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack |-> (addr_rnw && addr_match && addr_strobe))
        else $error("address accepted without a matching read");

    p_nack_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_hit && !addr_ack && !bus_stop && !cmd_strobe) |=> (state == ST_IDLE))
        else $error("refused address did not return to idle");

    p_send_from_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ack && !bus_stop && !cmd_strobe) |=> (tx_valid && cnt == '0))
        else $error("accepted address did not start at byte zero");

    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (cnt < resp_len))
        else $error("byte count beyond response length");

    p_last_drops_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_last && byte_req && !bus_stop && !bus_rstart && !cmd_strobe) |=> !tx_valid)
        else $error("offer continued after final byte");

    p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (!tx_valid && state == ST_IDLE))
        else $error("STOP did not return to idle");

endmodule

// File: tb/getccc_responder_bench.sv
module getccc_responder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_strobe = 0, cmd_has_db = 0;
    logic [7:0]  cmd_code = 0, cmd_db = 0;
    logic        addr_strobe = 0, addr_match = 0, addr_rnw = 0;
    logic        addr_ack;
    logic        byte_req = 0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_byte;
    logic        bus_stop = 0, bus_rstart = 0;
    logic [7:0]  dcr_in = 8'hC6, bcr_in = 8'h27;
    logic [31:0] pid_hi_in = 32'h1234_5678;
    logic [15:0] pid_lo_in = 16'h9ABC;
    logic [15:0] status_in = 16'hA5C0;
    logic        proto_err = 1'b1;
    logic [15:0] mwl_q = 16'h0100, mrl_q = 16'h00FF;
    logic [7:0]  ibil_q = 8'h08;
    logic [15:0] caps_in = 16'h0140;
    logic [7:0]  caps_ext_in = 8'h5A;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    getccc_responder u_getccc_responder (
        .clk(clk), .rst_n(rst_n),
        .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .cmd_has_db(cmd_has_db), .cmd_db(cmd_db),
        .addr_strobe(addr_strobe), .addr_match(addr_match), .addr_rnw(addr_rnw), .addr_ack(addr_ack),
        .byte_req(byte_req), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last),
        .bus_stop(bus_stop), .bus_rstart(bus_rstart),
        .dcr_in(dcr_in), .bcr_in(bcr_in), .pid_hi_in(pid_hi_in), .pid_lo_in(pid_lo_in),
        .status_in(status_in), .proto_err(proto_err), .mwl_q(mwl_q), .mrl_q(mrl_q),
        .ibil_q(ibil_q), .caps_in(caps_in), .caps_ext_in(caps_ext_in)
    );

    // Row: code(8) hasdb(4) db(8) rnw(4) ack(4) len(4) response left-justified (48)
    localparam int NROWS = 16;
    localparam logic [79:0] VECS [NROWS] = '{
        80'h8E_0_00_1_1_1_270000000000,
        80'h8F_0_00_1_1_1_C60000000000,
        80'h90_0_00_1_1_2_A5E000000000,
        80'h8B_0_00_1_1_2_010000000000,
        80'h8C_0_00_1_1_3_00FF08000000,
        80'h8D_0_00_1_1_6_123456789ABC,
        80'h95_0_00_1_1_2_014000000000,
        80'h95_1_93_1_1_1_5A0000000000,
        80'h9A_1_81_1_1_1_FF0000000000,
        80'h9A_1_82_1_1_1_FF0000000000,
        80'h9A_1_84_1_1_1_FF0000000000,
        80'h9A_1_00_1_0_0_000000000000,
        80'h8E_0_00_0_0_0_000000000000,
        80'h95_1_91_1_0_0_000000000000,
        80'h8E_1_00_1_0_0_000000000000,
        80'h20_0_00_1_0_0_000000000000
    };

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [7:0] code, input logic hdb, input logic [7:0] db);
        @(negedge clk);
        cmd_strobe = 1; cmd_code = code; cmd_has_db = hdb; cmd_db = db;
        @(negedge clk);
        cmd_strobe = 0;
    endtask

    task automatic do_addr(input logic match, input logic rnw, output logic ack);
        @(negedge clk);
        addr_strobe = 1; addr_match = match; addr_rnw = rnw;
        #1 ack = addr_ack;
        @(negedge clk);
        addr_strobe = 0;
    endtask

    task automatic read_byte(output logic v, output logic [7:0] b, output logic l);
        @(negedge clk);
        #1;
        v = tx_valid; b = tx_byte; l = tx_last;
        byte_req = 1;
        @(negedge clk);
        byte_req = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); bus_stop = 1;
        @(negedge clk); bus_stop = 0;
    endtask

    task automatic pulse_rstart();
        @(negedge clk); bus_rstart = 1;
        @(negedge clk); bus_rstart = 0;
    endtask

    function automatic string row_tag(input logic [7:0] code, input logic ack);
        if (!ack)                 return "R7";
        if (code == 8'h8C || code == 8'h8D) return "R2";
        if (code == 8'h90)        return "R4";
        if (code == 8'h95)        return "R5";
        if (code == 8'h9A)        return "R6";
        return "R1";
    endfunction

    initial begin
        #1_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic ack, v, l;
        logic [7:0] b;

        // R11: reset state
        #12;
        check("R11 tx_valid in reset", 48'(tx_valid), 48'h0);
        check("R11 addr_ack in reset", 48'(addr_ack), 48'h0);
        @(negedge clk); rst_n = 1;
        do_addr(1, 1, ack);
        check("R11 no ack without command", 48'(ack), 48'h0);

        // Table walk: R1 R2 R4 R5 R6 R7 R9
        for (int r = 0; r < NROWS; r++) begin
            logic [7:0]  code = VECS[r][79:72];
            logic        hdb  = VECS[r][68];
            logic [7:0]  db   = VECS[r][67:60];
            logic        rnw  = VECS[r][56];
            logic        eack = VECS[r][52];
            int          len  = int'(VECS[r][51:48]);
            logic [47:0] resp = VECS[r][47:0];
            string       tag  = row_tag(code, eack);
            do_cmd(code, hdb, db);
            do_addr(1, rnw, ack);
            check({tag, " ack"}, 48'(ack), 48'(eack));
            if (eack) begin
                for (int k = 0; k < len; k++) begin
                    read_byte(v, b, l);
                    check({tag, " valid"}, 48'(v), 48'h1);
                    check({tag, " byte"}, 48'(b), 48'(resp[47-8*k -: 8]));
                    check("R9 last flag", 48'(l), 48'(k == len - 1));
                end
            end
            #1;
            check("R9 valid low after response", 48'(tx_valid), 48'h0);
            pulse_stop();
        end

        // R4: error flag cleared
        proto_err = 0;
        do_cmd(8'h90, 0, 0);
        do_addr(1, 1, ack);
        read_byte(v, b, l);
        read_byte(v, b, l);
        check("R4 status LSB with flag clear", 48'(b), 48'hC0);
        pulse_stop();

        // R3: live source change between second and third ID byte
        do_cmd(8'h8D, 0, 0);
        do_addr(1, 1, ack);
        read_byte(v, b, l); check("R3 id byte0", 48'(b), 48'h12);
        read_byte(v, b, l); check("R3 id byte1", 48'(b), 48'h34);
        pid_hi_in = 32'hAABB_CCDD; pid_lo_in = 16'hEEFF;
        read_byte(v, b, l); check("R3 id byte2 new", 48'(b), 48'hCC);
        read_byte(v, b, l); check("R3 id byte3 new", 48'(b), 48'hDD);
        read_byte(v, b, l); check("R3 id byte4 new", 48'(b), 48'hEE);
        read_byte(v, b, l); check("R3 id byte5 new", 48'(b), 48'hFF);
        check("R3 id last", 48'(l), 48'h1);
        pulse_stop();

        // R8: mismatch stays armed
        do_cmd(8'h8E, 0, 0);
        do_addr(0, 1, ack);
        check("R8 mismatch not acked", 48'(ack), 48'h0);
        do_addr(1, 1, ack);
        check("R8 later match acked", 48'(ack), 48'h1);
        read_byte(v, b, l);
        check("R8 byte after rematch", 48'(b), 48'h27);
        pulse_stop();

        // R7: refusal leaves block idle
        do_cmd(8'h8F, 0, 0);
        do_addr(1, 0, ack);
        check("R7 write direction refused", 48'(ack), 48'h0);
        do_addr(1, 1, ack);
        check("R7 idle after refusal", 48'(ack), 48'h0);
        pulse_stop();

        // R10: repeated START rearms from byte zero, STOP aborts
        do_cmd(8'h8C, 0, 0);
        do_addr(1, 1, ack);
        read_byte(v, b, l);
        check("R10 first byte", 48'(b), 48'h00);
        pulse_rstart();
        #1 check("R10 valid low after rstart", 48'(tx_valid), 48'h0);
        do_addr(1, 1, ack);
        check("R10 rearmed ack", 48'(ack), 48'h1);
        read_byte(v, b, l);
        check("R10 restart at byte zero", 48'(b), 48'h00);
        read_byte(v, b, l);
        check("R10 second byte", 48'(b), 48'hFF);
        pulse_stop();
        #1 check("R10 valid low after stop", 48'(tx_valid), 48'h0);
        do_addr(1, 1, ack);
        check("R10 idle after stop", 48'(ack), 48'h0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule